// File: doc/BRIEF.md
# Calendar Real-Time Clock with Guarded Field Writes

This block keeps time of day and a calendar. An external one-pulse-per-second strobe drives it, and the strobe is high for one clock cycle. The block counts seconds, minutes and hours. It also tracks day of week, day of month, month and a two-digit year. The rules for month length and leap years are built into the counting logic. A second counter runs on the fast clock and measures how far into the current second the block is. Software can restart that counter.

Software reaches the block through a plain register bus. A write is a single-cycle `bus_wr` strobe carrying an address and a data byte. A read is combinational from `bus_addr` and always returns the committed value. A write to a time field only takes effect when the bus write just before it went to the key address. The block does not apply an accepted value at once. It holds the value as pending and loads it on the next second strobe, so every field changes at the same instant. The bus has no data stream and no back-pressure, so all pins are plain control and status.

Top module: `rtc_calendar`

## Requirements
- R1: On each second strobe, seconds count 0..59 and then wrap to 0. The wrap carries into minutes, which also count 0..59. A minute wrap carries into hours, which count 0..23 (0 is midnight).
- R2: Day of week holds 1..7, where 1 is Sunday. It advances when the hour wraps at midnight and goes from 7 back to 1.
- R3: Date advances at midnight. It returns to 1 after the last day of the month, which is 31, 30 for months 4/6/9/11, and 28 for month 2 (29 when year mod 4 is 0, year 0 included). Month goes 1..12 and carries into year. Year goes 0..99 and wraps to 0.
- R4: The bus addresses are: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 key, 8 sub-second counter. A write to addresses 0..6 is accepted only when the bus write just before it went to address 7. Any other field write is ignored.
- R5: The block loads an accepted field value on the next second strobe, not in the write cycle. The stored time changes only on a second strobe.
- R6: A read returns the committed field value. A pending write that has not been loaded stays invisible.
- R7: When a pending value and a natural carry hit the same field on the same strobe, the written value wins. Lower fields still advance normally.
- R8: The sub-second counter clears on each second strobe and otherwise adds one every clock. Address 8 reads it. Writing address 8 with bit 0 set clears it, and writing bit 0 clear has no effect.
- R9: Every bus write uses up the key, whether it was accepted or not, and whatever its address. Only a write to address 7 gives a new key.
- R10: After reset the time is 00:00:00, day of week 1, date 1, month 1, year 0, and the sub-second counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe at each second boundary |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
The results appear at different times after their stimulus:

- A second strobe sampled at rising edge N shows the new time on reads right after that edge, which is one register.
- A guarded field write shows nothing until a strobe follows it, and it appears after that strobe's edge.
- A sub-second restart reads zero right after the edge of the write.

The bench drives every input at the falling edge. It reads the combinational read-out 1 ns after a falling edge, so each result is sampled a whole half cycle after the edge that produced it. Expected times come from arithmetic on the stimulus: modulo counting for the minute and hour sweep, and a separate month-length function for the calendar sweep.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int NFIELD     = 7;
  localparam int ADR_SEC    = 0;
  localparam int ADR_MIN    = 1;
  localparam int ADR_HR     = 2;
  localparam int ADR_DOW    = 3;
  localparam int ADR_DATE   = 4;
  localparam int ADR_MON    = 5;
  localparam int ADR_YR     = 6;
  localparam int ADR_KEY    = 7;
  localparam int ADR_SUBSEC = 8;

  typedef struct packed {
    logic [7:0] yr;
    logic [3:0] mon;
    logic [4:0] date;
    logic [2:0] dow;
    logic [4:0] hr;
    logic [5:0] min;
    logic [5:0] sec;
  } caltime_t;

  function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [7:0] yr);
    case (mon)
      4'd2:                   return (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_wr_guard.sv
module rtc_wr_guard
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       wr,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [7:0]                 wdata,
  output logic [NFIELD-1:0]          load_mask,
  output logic [NFIELD-1:0][7:0]     load_val
);
  logic              armed_q;
  logic              field_hit;
  logic [NFIELD-1:0] pend_q;

  // every write uses up the key; only the key address sets it again
  always_ff @(posedge clk) begin
    if (!rst_n)  armed_q <= 1'b0;
    else if (wr) armed_q <= (addr == ADDR_W'(ADR_KEY));
  end

  assign field_hit = wr && armed_q && (int'(addr) < NFIELD);

  for (genvar i = 0; i < NFIELD; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[i]   <= 1'b0;
        load_val[i] <= 8'd0;
      end else begin
        pend_q[i] <= (pend_q[i] && !tick) || (field_hit && addr == ADDR_W'(i));
        if (field_hit && addr == ADDR_W'(i)) load_val[i] <= wdata;
      end
    end
  end

  assign load_mask = pend_q & {NFIELD{tick}};

  // R4: a field write without the key leaves pending state alone
  p_unkeyed_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !armed_q && int'(addr) < NFIELD && !tick) |=> (pend_q == $past(pend_q)));
  // R9: a non-key write leaves no key behind
  p_key_consumed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr != ADDR_W'(ADR_KEY)) |=> !armed_q);
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic [NFIELD-1:0]      load_mask,
  input  logic [NFIELD-1:0][7:0] load_val,
  output caltime_t               now
);
  caltime_t nat, nxt;
  logic s_wrap, m_wrap, h_wrap, d_wrap, mo_wrap;
  logic unused_hi;

  assign unused_hi = ^load_val;

  always_comb begin
    s_wrap  = now.sec >= 6'd59;
    m_wrap  = s_wrap && now.min >= 6'd59;
    h_wrap  = m_wrap && now.hr >= 5'd23;
    d_wrap  = h_wrap && now.date >= month_len(now.mon, now.yr);
    mo_wrap = d_wrap && now.mon >= 4'd12;
    nat      = now;
    nat.sec  = s_wrap ? 6'd0 : now.sec + 6'd1;
    if (s_wrap)  nat.min  = (now.min >= 6'd59) ? 6'd0 : now.min + 6'd1;
    if (m_wrap)  nat.hr   = (now.hr >= 5'd23) ? 5'd0 : now.hr + 5'd1;
    if (h_wrap)  nat.dow  = (now.dow >= 3'd7) ? 3'd1 : now.dow + 3'd1;
    if (h_wrap)  nat.date = d_wrap ? 5'd1 : now.date + 5'd1;
    if (d_wrap)  nat.mon  = mo_wrap ? 4'd1 : now.mon + 4'd1;
    if (mo_wrap) nat.yr   = (now.yr >= 8'd99) ? 8'd0 : now.yr + 8'd1;
    // written values override the natural carry
    nxt      = nat;
    if (load_mask[ADR_SEC])  nxt.sec  = load_val[ADR_SEC][5:0];
    if (load_mask[ADR_MIN])  nxt.min  = load_val[ADR_MIN][5:0];
    if (load_mask[ADR_HR])   nxt.hr   = load_val[ADR_HR][4:0];
    if (load_mask[ADR_DOW])  nxt.dow  = load_val[ADR_DOW][2:0];
    if (load_mask[ADR_DATE]) nxt.date = load_val[ADR_DATE][4:0];
    if (load_mask[ADR_MON])  nxt.mon  = load_val[ADR_MON][3:0];
    if (load_mask[ADR_YR])   nxt.yr   = load_val[ADR_YR];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) now <= '{yr: 8'd0, mon: 4'd1, date: 5'd1, dow: 3'd1, hr: 5'd0, min: 6'd0, sec: 6'd0};
    else if (tick) now <= nxt;
  end

  // R5: time is frozen between strobes
  p_hold_between_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (now == $past(now)));
  // R1: seconds wrap from 59 to 0
  p_sec_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_mask[ADR_SEC] && now.sec == 6'd59) |=> (now.sec == 6'd0));
  // R2: weekday wraps 7 -> 1 at midnight
  p_dow_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && load_mask == '0 && now.hr == 5'd23 && now.min == 6'd59 && now.sec == 6'd59
     && now.dow == 3'd7) |=> (now.dow == 3'd1));
  // R7: a pending minute write wins over the carry
  p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && load_mask[ADR_MIN]) |=> (now.min == $past(load_val[ADR_MIN][5:0])));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int SUBSEC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  logic [NFIELD-1:0]      load_mask;
  logic [NFIELD-1:0][7:0] load_val;
  caltime_t               now;
  logic [SUBSEC_W-1:0]    subsec_q;
  logic                   restart;

  rtc_wr_guard #(.ADDR_W(ADDR_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .load_mask(load_mask), .load_val(load_val)
  );

  rtc_time_chain u_chain (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .load_mask(load_mask),
    .load_val(load_val), .now(now)
  );

  assign restart = bus_wr && bus_addr == ADDR_W'(ADR_SUBSEC) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n || sec_tick || restart) subsec_q <= '0;
    else                               subsec_q <= subsec_q + 1'b1;
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(ADR_SEC):    bus_rdata = 8'(now.sec);
      ADDR_W'(ADR_MIN):    bus_rdata = 8'(now.min);
      ADDR_W'(ADR_HR):     bus_rdata = 8'(now.hr);
      ADDR_W'(ADR_DOW):    bus_rdata = 8'(now.dow);
      ADDR_W'(ADR_DATE):   bus_rdata = 8'(now.date);
      ADDR_W'(ADR_MON):    bus_rdata = 8'(now.mon);
      ADDR_W'(ADR_YR):     bus_rdata = now.yr;
      ADDR_W'(ADR_SUBSEC): bus_rdata = 8'(subsec_q);
      default:             bus_rdata = 8'd0;
    endcase
  end

  // R8: restart clears the sub-second counter
  p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (subsec_q == '0));
endmodule

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_calendar uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic bwrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic keyed(input logic [3:0] a, input logic [7:0] d);
    bwrite(4'd7, 8'h00);
    bwrite(a, d);
  endtask

  task automatic chk(input string req, input logic [3:0] a, input int exp);
    bus_addr = a; #1;
    n_run++;
    if (int'(bus_rdata) != exp) begin
      n_fail++;
      $display("FAIL %s addr %0d: actual %0d expected %0d", req, a, bus_rdata, exp);
    end
  endtask

  task automatic chk_time(input string req, input int s, input int m, input int h,
                          input int dw, input int dt, input int mo, input int y);
    chk(req, 4'd0, s); chk(req, 4'd1, m); chk(req, 4'd2, h); chk(req, 4'd3, dw);
    chk(req, 4'd4, dt); chk(req, 4'd5, mo); chk(req, 4'd6, y);
  endtask

  task automatic load_time(input int s, input int m, input int h, input int dw,
                           input int dt, input int mo, input int y);
    keyed(4'd0, 8'(s)); keyed(4'd1, 8'(m)); keyed(4'd2, 8'(h)); keyed(4'd3, 8'(dw));
    keyed(4'd4, 8'(dt)); keyed(4'd5, 8'(mo)); keyed(4'd6, 8'(y));
    do_tick();
  endtask

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    chk_time("R10", 0, 0, 0, 1, 1, 1, 0);
    // R4: field write without key is ignored
    bwrite(4'd0, 8'd30);
    do_tick();
    chk("R4", 4'd0, 1);
    // R9: an intervening write (subsec, bit0 clear) uses up the key
    bwrite(4'd7, 8'h00);
    bwrite(4'd8, 8'h00);
    bwrite(4'd1, 8'd40);
    do_tick();
    chk("R9", 4'd1, 0);
    chk("R9", 4'd0, 2);
    // R6 / R5: pending invisible until the strobe
    keyed(4'd1, 8'd20);
    chk("R6", 4'd1, 0);
    repeat (4) @(negedge clk);
    chk("R5", 4'd1, 0);
    do_tick();
    chk("R5", 4'd1, 20);
    chk("R5", 4'd0, 3);
    // R7: written minute and hour win over carry, seconds still wrap
    load_time(59, 59, 3, 2, 5, 6, 10);
    chk_time("R5", 59, 59, 3, 2, 5, 6, 10);
    keyed(4'd1, 8'd33);
    keyed(4'd2, 8'd7);
    do_tick();
    chk_time("R7", 0, 33, 7, 2, 5, 6, 10);
    // R1: sweep one hour of seconds and minutes
    load_time(0, 0, 5, 1, 1, 1, 0);
    for (int k = 1; k <= 3600; k++) begin
      do_tick();
      chk("R1", 4'd0, k % 60);
      chk("R1", 4'd1, (k / 60) % 60);
      chk("R1", 4'd2, 5 + k / 3600);
    end
    // R1/R2: midnight, weekday 7 -> 1
    load_time(59, 59, 23, 7, 10, 5, 20);
    do_tick();
    chk_time("R2", 0, 0, 0, 1, 11, 5, 20);
    load_time(59, 59, 22, 4, 10, 5, 20);
    do_tick();
    chk_time("R1", 0, 0, 23, 4, 10, 5, 20);
    // R3: end of every month over several years, including 99 -> 0
    for (int yi = 0; yi < 9; yi++) begin
      int y;
      y = (yi < 5) ? yi : yi + 91;
      for (int mo = 1; mo <= 12; mo++) begin
        load_time(59, 59, 23, 3, dim(mo, y), mo, y);
        do_tick();
        chk_time("R3", 0, 0, 0, 4, 1, (mo == 12) ? 1 : mo + 1,
                 (mo == 12) ? ((y == 99) ? 0 : y + 1) : y);
      end
      load_time(59, 59, 23, 3, 28, 2, y);
      do_tick();
      chk("R3", 4'd4, (y % 4 == 0) ? 29 : 1);
    end
    // R8: sub-second counter
    do_tick();
    repeat (5) @(negedge clk);
    chk("R8", 4'd8, 5);
    bwrite(4'd8, 8'h01);
    chk("R8", 4'd8, 0);
    bwrite(4'd8, 8'h00);
    chk("R8", 4'd8, 2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule